// File: doc/BRIEF.md
# Timer/Counter and Watchdog with Shared Prescaler

This block holds an 8-bit real-time counter and a watchdog counter. One 8-bit programmable prescaler serves both of them. A write-only mode register controls the block. Its fields choose three things: which side the prescaler serves, the divide ratio, and the counter's clock source. That source is either the instruction-cycle enable or a pin that is already synchronised, counted on a selectable edge. The watchdog advances on ticks from an on-chip RC oscillator, each tick being a one-cycle enable. When the watchdog count rolls over, it issues a one-cycle reset pulse. It also clears a time-out flag and reloads the low six bits of the mode register with ones.

The CPU drives the strobes for the clear-watchdog and sleep instructions, and it reads and writes the counter through a simple register port. The prescaler sits either ahead of the counter or behind the watchdog. The ratio codes therefore select powers of two that differ by one step between the two placements. The side that does not own the prescaler counts every qualifying event directly.

Top module: `tmr_wdt_core`

## Requirements
- R1: After asynchronous reset the counter reads 0x00, the time-out flag and the power-loss flag read 1, and the mode register holds 0xFF. With FORCE_WDT=0 the watchdog is therefore disabled, and watchdog ticks produce no reset pulse.
- R2: Mode bit 3 = 0 assigns the prescaler to the counter. The counter then advances once per 2^(k+1) clock events, where k is mode bits 2:0. For example, code 0 divides by 2 and code 7 divides by 256.
- R3: Mode bit 3 = 1 leaves the counter unprescaled, so it advances by one on every clock event. It wraps from 0xFF to 0x00.
- R4: Mode bit 5 = 0 clocks the counter from the instruction-cycle enable. Mode bit 5 = 1 clocks it from pin transitions, and the cycle enable then has no effect on the counter.
- R5: Mode bit 4 = 0 counts low-to-high pin transitions. Mode bit 4 = 1 counts high-to-low transitions.
- R6: With the prescaler on the watchdog, every 2^k ticks advance the 8-bit watchdog count by one, so it expires after 256*2^k ticks. With the prescaler on the counter, it expires after 256 ticks.
- R7: Mode bit 7 enables the watchdog when 0 and disables it when 1. A disabled watchdog never expires. The parameter FORCE_WDT=1 keeps it enabled whatever bit 7 holds.
- R8: A clear-watchdog strobe or a sleep strobe sets the watchdog count to zero. If the prescaler is on the watchdog, the strobe also clears the prescaler. A strobe in the same cycle as an expiry prevents the reset.
- R9: A counter write loads the written value and clears the prescaler count. It takes priority over an increment in the same cycle.
- R10: On expiry wdt_rst is high for exactly one cycle and the time-out flag is cleared to 0. Mode bits 5:0 become ones and bits 7:6 keep their values. The counter value does not change.
- R11: An expiry after a sleep strobe also clears the power-loss flag, and an expiry without sleep leaves that flag alone. A clear-watchdog strobe sets both flags to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle clock enable |
| ext_pin | input | 1 | Synchronised external counter pin |
| wdt_tick | input | 1 | Watchdog oscillator tick, one cycle per tick |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| clrwdt | input | 1 | Clear-watchdog strobe |
| sleep | input | 1 | Sleep strobe |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CW | Counter write data |
| cnt_q | output | CW | Counter value |
| wdt_rst | output | 1 | Watchdog reset pulse |
| tof | output | 1 | Time-out flag, cleared by expiry |
| pwr_flag | output | 1 | Power-loss flag, cleared by expiry during sleep |

## Verification
The checks assume that every strobe is a single-cycle pulse sampled at a rising clock edge. They also assume that ext_pin is already synchronised to clk, so that each change of level is one transition. The bench drives every input at the falling edge, so each stimulus is held for exactly one rising edge. It keeps the pin low or high for at least one full cycle between changes. During watchdog tests it holds the counter write and mode write strobes low, so any change to the watchdog count comes only from ticks and strobes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic       wdt_off;
    logic       spare;
    logic       src_pin;
    logic       edge_fall;
    logic       pre_wdt;
    logic [2:0] ratio;
  } mode_t;

  localparam int MODE_W = 8;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev,
  input  logic       clr,
  input  logic [2:0] ratio,
  input  logic       to_wdt,
  output logic       pulse
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic [3:0]    shift;
  logic [PW:0]   full;
  logic [PW-1:0] mask;

  always_comb begin
    shift = to_wdt ? {1'b0, ratio} : ({1'b0, ratio} + 4'd1);
    full  = ({{PW{1'b0}}, 1'b1} << shift) - {{PW{1'b0}}, 1'b1};
    mask  = full[PW-1:0];
    pulse = ev & ((cnt_q & mask) == mask);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (ev)
      cnt_d = cnt_q + {{(PW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_rtc.sv
module tmr_rtc #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] q
);
  logic [CW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we)
      q_d = wdata;
    else if (inc)
      q_d = q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog #(
  parameter int WW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clr,
  output logic expire
);
  logic [WW-1:0] cnt_q, cnt_d;

  always_comb begin
    expire = adv & ~clr & (&cnt_q);
    cnt_d  = cnt_q;
    if (clr || expire)
      cnt_d = '0;
    else if (adv)
      cnt_d = cnt_q + {{(WW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_wdt_core.sv
module tmr_wdt_core
  import tmr_pkg::*;
#(
  parameter int CW        = 8,
  parameter int WW        = 8,
  parameter int PW        = 8,
  parameter bit FORCE_WDT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_en,
  input  logic          ext_pin,
  input  logic          wdt_tick,
  input  logic          mode_we,
  input  logic [7:0]    mode_wdata,
  input  logic          clrwdt,
  input  logic          sleep,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  output logic [CW-1:0] cnt_q,
  output logic          wdt_rst,
  output logic          tof,
  output logic          pwr_flag
);
  mode_t mode_q, mode_d;
  logic  pin_d;
  logic  asleep_q, asleep_d;
  logic  tof_d, pwr_d;
  logic  wdt_on, pin_edge, cnt_ev, wdt_ev;
  logic  pre_ev, pre_clr, pre_pulse;
  logic  rtc_inc, wdog_adv, wdog_clr, expire;

  always_comb begin
    wdt_on   = FORCE_WDT | ~mode_q.wdt_off;
    pin_edge = mode_q.edge_fall ? (pin_d & ~ext_pin) : (~pin_d & ext_pin);
    cnt_ev   = mode_q.src_pin ? pin_edge : cyc_en;
    wdt_ev   = wdt_tick & wdt_on;
    pre_ev   = mode_q.pre_wdt ? wdt_ev : cnt_ev;
    pre_clr  = cnt_we | expire | (mode_q.pre_wdt & (clrwdt | sleep));
    rtc_inc  = mode_q.pre_wdt ? cnt_ev : pre_pulse;
    wdog_adv = mode_q.pre_wdt ? pre_pulse : wdt_ev;
    wdog_clr = clrwdt | sleep;
  end

  tmr_prescaler #(.PW(PW)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (pre_ev),
    .clr    (pre_clr),
    .ratio  (mode_q.ratio),
    .to_wdt (mode_q.pre_wdt),
    .pulse  (pre_pulse)
  );

  tmr_rtc #(.CW(CW)) u_rtc (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (rtc_inc),
    .we    (cnt_we),
    .wdata (cnt_wdata),
    .q     (cnt_q)
  );

  tmr_wdog #(.WW(WW)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (wdog_adv),
    .clr    (wdog_clr),
    .expire (expire)
  );

  always_comb begin
    mode_d = mode_q;
    if (expire)
      mode_d = mode_t'({mode_q.wdt_off, mode_q.spare, 6'h3F});
    else if (mode_we)
      mode_d = mode_t'(mode_wdata);

    tof_d = tof;
    if (expire)      tof_d = 1'b0;
    else if (clrwdt) tof_d = 1'b1;

    pwr_d = pwr_flag;
    if (expire && asleep_q) pwr_d = 1'b0;
    else if (clrwdt)        pwr_d = 1'b1;

    asleep_d = asleep_q;
    if (expire)     asleep_d = 1'b0;
    else if (sleep) asleep_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= mode_t'({MODE_W{1'b1}});
      pin_d    <= 1'b0;
      asleep_q <= 1'b0;
      tof      <= 1'b1;
      pwr_flag <= 1'b1;
      wdt_rst  <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      pin_d    <= ext_pin;
      asleep_q <= asleep_d;
      tof      <= tof_d;
      pwr_flag <= pwr_d;
      wdt_rst  <= expire;
    end
  end
endmodule

// File: rtl/tmr_wdt_chk.sv
module tmr_wdt_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_we,
  input logic [CW-1:0] cnt_wdata,
  input logic [CW-1:0] cnt_q,
  input logic          clrwdt,
  input logic          sleep,
  input logic          wdt_rst,
  input logic          tof,
  input logic          pwr_flag,
  input logic          wdt_on
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst); // R10

  AST_TOF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> !tof); // R10

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(cnt_wdata))); // R9

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CW'(1))); // R3

  AST_CLR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clrwdt || sleep) |=> !wdt_rst); // R8

  AST_OFF_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_on |=> !wdt_rst); // R7

  AST_PWR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_flag) |-> wdt_rst); // R11
endmodule

bind tmr_wdt_core tmr_wdt_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_we    (cnt_we),
  .cnt_wdata (cnt_wdata),
  .cnt_q     (cnt_q),
  .clrwdt    (clrwdt),
  .sleep     (sleep),
  .wdt_rst   (wdt_rst),
  .tof       (tof),
  .pwr_flag  (pwr_flag),
  .wdt_on    (wdt_on)
);

// File: tb/tmr_wdt_core_test.sv
`timescale 1ns/1ps
module tmr_wdt_core_test;
  logic       clk = 1'b0;
  logic       rst_n, cyc_en, ext_pin, wdt_tick, mode_we, clrwdt, sleep, cnt_we;
  logic [7:0] mode_wdata, cnt_wdata, cnt_q;
  logic       wdt_rst, tof, pwr_flag;

  int total = 0;
  int bad = 0;
  int nrst = 0;
  int exp_rst = 0;

  always #10 clk = ~clk;

  tmr_wdt_core uut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .clrwdt(clrwdt), .sleep(sleep), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cnt_q(cnt_q), .wdt_rst(wdt_rst), .tof(tof), .pwr_flag(pwr_flag)
  );

  always @(negedge clk) if (rst_n && wdt_rst) nrst++;

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic check(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_mode(input logic [7:0] v);
    mode_we = 1'b1; mode_wdata = v; step(); mode_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_we = 1'b1; cnt_wdata = v; step(); cnt_we = 1'b0;
  endtask

  task automatic pulse_clr();
    clrwdt = 1'b1; step(); clrwdt = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep = 1'b1; step(); sleep = 1'b0;
  endtask

  task automatic cyc_pulses(input int n);
    if (n > 0) begin cyc_en = 1'b1; repeat (n) step(); cyc_en = 1'b0; end
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin wdt_tick = 1'b1; repeat (n) step(); wdt_tick = 1'b0; end
  endtask

  task automatic pin_toggles(input int n);
    repeat (n) begin ext_pin = ~ext_pin; step(); step(); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung actual=1 expected=0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cyc_en = 1'b0; ext_pin = 1'b0; wdt_tick = 1'b0;
    mode_we = 1'b0; mode_wdata = 8'h00; clrwdt = 1'b0; sleep = 1'b0;
    cnt_we = 1'b0; cnt_wdata = 8'h00;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 counter reset", cnt_q, 8'h00);
    check("R1 tof reset", tof, 1);
    check("R1 pwr reset", pwr_flag, 1);
    ticks(300); step();
    check("R1 watchdog off after reset", nrst, 0);

    // R2: counter-side prescale sweep, watchdog disabled
    for (int k = 0; k < 8; k++) begin
      int d;
      d = 1 << (k + 1);
      wr_mode(8'h80 | k[7:0]);
      wr_cnt(8'h20);
      cyc_pulses(3 * d + d - 1);
      check($sformatf("R2 ratio code %0d before step", k), cnt_q, 8'h23);
      cyc_pulses(1);
      check($sformatf("R2 ratio code %0d at step", k), cnt_q, 8'h24);
    end

    // R9: write clears prescaler (divide by 8)
    wr_mode(8'h82);
    wr_cnt(8'h00);
    cyc_pulses(5);
    wr_cnt(8'h10);
    cyc_pulses(7);
    check("R9 prescaler cleared by write", cnt_q, 8'h10);
    cyc_pulses(1);
    check("R9 first step after write", cnt_q, 8'h11);

    // R3: direct counting and wrap
    wr_mode(8'h88);
    wr_cnt(8'hFD);
    cyc_pulses(3);
    check("R3 direct count wraps", cnt_q, 8'h00);
    // R9: write beats simultaneous increment
    cyc_en = 1'b1;
    wr_cnt(8'h50);
    cyc_en = 1'b0;
    step();
    check("R9 write priority over increment", cnt_q, 8'h50);

    // R4 and R5: pin source, rising then falling
    wr_mode(8'hA8);
    cyc_pulses(10);
    check("R4 cycle enable ignored on pin source", cnt_q, 8'h50);
    pin_toggles(6);
    check("R5 rising edges counted", cnt_q, 8'h53);
    wr_mode(8'hB8);
    pin_toggles(6);
    check("R5 falling edges counted", cnt_q, 8'h56);
    wr_mode(8'h88);
    cyc_pulses(4);
    check("R4 cycle enable source", cnt_q, 8'h5A);

    // R7: disabled watchdog, then enabled direct
    wr_mode(8'h80);
    ticks(400); step();
    check("R7 disabled watchdog never expires", nrst, 0);
    wr_mode(8'h00);
    pulse_clr();
    ticks(255); step();
    check("R6 direct watchdog before expiry", nrst, 0);
    ticks(1); step();
    check("R6 direct watchdog expires at 256", nrst, 1);
    check("R10 tof cleared", tof, 0);
    check("R11 pwr kept without sleep", pwr_flag, 1);

    // R8: clear and sleep restart the count
    wr_mode(8'h00);
    pulse_clr();
    check("R11 clrwdt sets tof", tof, 1);
    ticks(200); pulse_clr();
    ticks(255); step();
    check("R8 clrwdt restarts count", nrst, 1);
    pulse_sleep();
    ticks(255); step();
    check("R8 sleep restarts count", nrst, 1);
    ticks(1); step();
    check("R11 expiry during sleep", nrst, 2);
    check("R11 pwr cleared after sleep expiry", pwr_flag, 0);
    check("R11 tof cleared after sleep expiry", tof, 0);
    pulse_clr();
    check("R11 clrwdt sets pwr", pwr_flag, 1);

    // R6: watchdog-side prescale sweep
    exp_rst = 2;
    wr_cnt(8'h77);
    for (int k = 0; k < 8; k++) begin
      int n;
      n = 256 << k;
      wr_mode(8'h08 | k[7:0]);
      pulse_clr();
      ticks(n - 1); step();
      check($sformatf("R6 code %0d before expiry", k), nrst, exp_rst);
      ticks(1); step();
      exp_rst++;
      check($sformatf("R6 code %0d expiry", k), nrst, exp_rst);
    end

    // R10: mode low bits now ones, bits 7:6 kept (watchdog still on)
    check("R10 counter unchanged by expiry", cnt_q, 8'h77);
    cyc_pulses(5);
    check("R10 source forced to pin", cnt_q, 8'h77);
    pin_toggles(4);
    check("R10 falling edge, direct count", cnt_q, 8'h79);
    pulse_clr();
    ticks(32767); step();
    check("R10 ratio forced to 128 before expiry", nrst, exp_rst);
    ticks(1); step();
    exp_rst++;
    check("R10 ratio forced to 128 expiry", nrst, exp_rst);

    finish_run();
  end
endmodule